// File: doc/BRIEF.md
# Dual-LFSR Hex Random Display Generator

This block produces a new 8-bit pseudo-random value on every clock edge where the advance input is high. It shows that value as two hexadecimal digits on a pair of 7-segment displays. There is no data input. The randomness comes from two free-running linear feedback shift registers.

A 16-bit register supplies the candidate data bits. An independent 8-bit register supplies one steering bit for each output bit. Each output bit is chosen by its own 2-to-1 selector, which picks from an adjacent pair of data bits. The low nibble of the result is decoded onto the first display and the high nibble onto the second. Both displays use active-high segments.

Top module: `dual_lfsr_hex_rng`

## Requirements
- R1: While `rst_n` is low, the steering register loads 8'h01 and the data register loads 16'hACE1. With these seeds the value is 8'h28, so `seg_o` reads {7'h5B, 7'h7F}.
- R2: On each advancing edge, the 8-bit steering register shifts toward its MSB. Its new bit 0 is the XOR of its previous bits 7, 5, 4 and 3.
- R3: On each advancing edge, the 16-bit data register shifts toward its MSB. Its new bit 0 is the XOR of its previous bits 15, 13, 12 and 10.
- R4: Both registers step on the same rising clock edge and only when `en_i` is high. While `en_i` is low, both registers and `seg_o` keep their values.
- R5: Value bit i is data bit 2i when steering bit i is 0, and data bit 2i+1 when steering bit i is 1.
- R6: `seg_o[6:0]` shows value bits 3:0 and `seg_o[13:7]` shows value bits 7:4. Within each 7-bit group, segment a is the lowest bit and segment g the highest. The outputs follow the register state combinationally, with no extra register stage.
- R7: Digits 0 to F are encoded as 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F, 77, 7C, 39, 5E, 79, 71 (hex, bit 0 = segment a).
- R8: Neither register ever holds all zeros. Over a long enabled run, every hex digit appears on both displays.
- R9: Asserting `rst_n` in the middle of a run restarts both sequences from the seeds of R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock (50 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset, loads the seeds |
| en_i | input | 1 | Advance enable; both registers step when high |
| seg_o | output | 14 | Active-high segments, display 0 in bits 6:0, display 1 in bits 13:7 |

## Verification
The bench first runs a long stretch with enable held high. Every cycle is compared against a reference model of both shift registers and the pairwise selector. Any error in a feedback tap, a selector pairing or a digit code then separates from the model within a few steps. Next, enable is held low for a while and then toggled in irregular patterns. These separate a design that ignores enable, or steps only one register, from one that gates both together. A reset in the middle of a run checks that the sequence restarts from the seeds rather than continuing. The bench also tallies which digits appear on each display, which catches a register that locks up or a decoder that never produces some digits.

// File: rtl/rng_hex_pkg.sv
package rng_hex_pkg;

   typedef logic [6:0] seg7_t;

   // Active-high 7-segment code, bit 0 = segment a ... bit 6 = segment g
   function automatic seg7_t hex_to_seg7(input logic [3:0] nib);
      seg7_t s;
      case (nib)
         4'h0: s = 7'h3F;
         4'h1: s = 7'h06;
         4'h2: s = 7'h5B;
         4'h3: s = 7'h4F;
         4'h4: s = 7'h66;
         4'h5: s = 7'h6D;
         4'h6: s = 7'h7D;
         4'h7: s = 7'h07;
         4'h8: s = 7'h7F;
         4'h9: s = 7'h6F;
         4'hA: s = 7'h77;
         4'hB: s = 7'h7C;
         4'hC: s = 7'h39;
         4'hD: s = 7'h5E;
         4'hE: s = 7'h79;
         default: s = 7'h71;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/rng_lfsr.sv
// Fibonacci shift register: shifts toward MSB, feedback enters at bit 0.
module rng_lfsr #(
   parameter int unsigned   W    = 8,
   parameter logic [W-1:0]  TAPS = 8'hB8,
   parameter logic [W-1:0]  SEED = 8'h01
) (
   input  logic         clk_i,
   input  logic         rst_n,
   input  logic         step_i,
   output logic [W-1:0] state_o
);
   if (W < 3) begin : g_bad_width
      $error("rng_lfsr: width must be at least 3");
   end
   if (SEED == '0) begin : g_bad_seed
      $error("rng_lfsr: seed must be nonzero");
   end
   if (TAPS[W-1] != 1'b1) begin : g_bad_taps
      $error("rng_lfsr: tap mask must include the MSB");
   end

   logic [W-1:0] state_q;
   logic         fb;

   assign fb = ^(state_q & TAPS);

   always_ff @(posedge clk_i or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEED;
      end else if (step_i) begin
         state_q <= {state_q[W-2:0], fb};
      end
   end

   assign state_o = state_q;
endmodule

// File: rtl/rng_pair_select.sv
// Bank of 2:1 selectors: out[i] = data[2i + sel[i]].
module rng_pair_select #(
   parameter int unsigned OUT_W = 8,
   localparam int unsigned IN_W = 2 * OUT_W
) (
   input  logic [IN_W-1:0]  data_i,
   input  logic [OUT_W-1:0] sel_i,
   output logic [OUT_W-1:0] out_o
);
   if (OUT_W < 1) begin : g_bad_w
      $error("rng_pair_select: OUT_W must be positive");
   end

   for (genvar i = 0; i < OUT_W; i++) begin : g_mux
      assign out_o[i] = sel_i[i] ? data_i[2*i+1] : data_i[2*i];
   end
endmodule

// File: rtl/rng_hex_seg.sv
// Splits a value into nibbles and decodes each onto one display.
module rng_hex_seg
   import rng_hex_pkg::*;
#(
   parameter int unsigned VAL_W  = 8,
   localparam int unsigned DIGITS = VAL_W / 4,
   localparam int unsigned SEG_W  = 7 * DIGITS
) (
   input  logic [VAL_W-1:0] val_i,
   output logic [SEG_W-1:0] seg_o
);
   if (VAL_W % 4 != 0 || VAL_W == 0) begin : g_bad_w
      $error("rng_hex_seg: VAL_W must be a nonzero multiple of 4");
   end

   for (genvar d = 0; d < DIGITS; d++) begin : g_digit
      assign seg_o[7*d +: 7] = hex_to_seg7(val_i[4*d +: 4]);
   end
endmodule

// File: rtl/dual_lfsr_hex_rng.sv
module dual_lfsr_hex_rng #(
   parameter int unsigned        DATA_W    = 16,
   parameter int unsigned        SEL_W     = 8,
   parameter logic [DATA_W-1:0]  DATA_TAPS = 16'hB400,
   parameter logic [DATA_W-1:0]  DATA_SEED = 16'hACE1,
   parameter logic [SEL_W-1:0]   SEL_TAPS  = 8'hB8,
   parameter logic [SEL_W-1:0]   SEL_SEED  = 8'h01,
   localparam int unsigned       SEG_W     = 7 * (SEL_W / 4)
) (
   input  logic             clk_i,
   input  logic             rst_n,
   input  logic             en_i,
   output logic [SEG_W-1:0] seg_o
);
   if (DATA_W != 2 * SEL_W) begin : g_bad_ratio
      $error("dual_lfsr_hex_rng: DATA_W must be twice SEL_W");
   end
   if (SEL_W % 4 != 0) begin : g_bad_sel
      $error("dual_lfsr_hex_rng: SEL_W must be a multiple of 4");
   end

   logic [DATA_W-1:0] st_data;
   logic [SEL_W-1:0]  st_sel;
   logic [SEL_W-1:0]  rnd;

   rng_lfsr #(.W(DATA_W), .TAPS(DATA_TAPS), .SEED(DATA_SEED)) u_data_lfsr (
      .clk_i   (clk_i),
      .rst_n   (rst_n),
      .step_i  (en_i),
      .state_o (st_data)
   );

   rng_lfsr #(.W(SEL_W), .TAPS(SEL_TAPS), .SEED(SEL_SEED)) u_sel_lfsr (
      .clk_i   (clk_i),
      .rst_n   (rst_n),
      .step_i  (en_i),
      .state_o (st_sel)
   );

   rng_pair_select #(.OUT_W(SEL_W)) u_select (
      .data_i (st_data),
      .sel_i  (st_sel),
      .out_o  (rnd)
   );

   rng_hex_seg #(.VAL_W(SEL_W)) u_seg (
      .val_i (rnd),
      .seg_o (seg_o)
   );
endmodule

// File: rtl/dual_lfsr_hex_rng_chk.sv
module dual_lfsr_hex_rng_chk #(
   parameter int unsigned        DATA_W    = 16,
   parameter int unsigned        SEL_W     = 8,
   parameter logic [DATA_W-1:0]  DATA_TAPS = 16'hB400,
   parameter logic [SEL_W-1:0]   SEL_TAPS  = 8'hB8,
   localparam int unsigned       SEG_W     = 7 * (SEL_W / 4)
) (
   input logic              clk_i,
   input logic              rst_n,
   input logic              en_i,
   input logic [DATA_W-1:0] st_data,
   input logic [SEL_W-1:0]  st_sel,
   input logic [SEL_W-1:0]  rnd,
   input logic [SEG_W-1:0]  seg_o
);
   // R8: no register ever reaches the all-zero lock state
   p_sel_nonzero_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
      st_sel != '0);
   p_data_nonzero_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
      st_data != '0);

   // R4: disabled cycle keeps all state and the display
   p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
      !en_i |=> ($stable(st_sel) && $stable(st_data) && $stable(seg_o)));

   // R2: steering register shift and feedback
   p_sel_step_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
      en_i |=> (st_sel[SEL_W-1:1] == $past(st_sel[SEL_W-2:0])
                && st_sel[0] == ^($past(st_sel) & SEL_TAPS)));

   // R3: data register shift and feedback
   p_data_step_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
      en_i |=> (st_data[DATA_W-1:1] == $past(st_data[DATA_W-2:0])
                && st_data[0] == ^($past(st_data) & DATA_TAPS)));

   // R5: each value bit comes from its own adjacent data pair
   for (genvar i = 0; i < SEL_W; i++) begin : g_pair
      p_pair_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
         rnd[i] == (st_sel[i] ? st_data[2*i+1] : st_data[2*i]));
   end
endmodule

bind dual_lfsr_hex_rng dual_lfsr_hex_rng_chk #(
   .DATA_W    (DATA_W),
   .SEL_W     (SEL_W),
   .DATA_TAPS (DATA_TAPS),
   .SEL_TAPS  (SEL_TAPS)
) u_chk (
   .clk_i   (clk_i),
   .rst_n   (rst_n),
   .en_i    (en_i),
   .st_data (st_data),
   .st_sel  (st_sel),
   .rnd     (rnd),
   .seg_o   (seg_o)
);

// File: tb/dual_lfsr_hex_rng_tb.sv
module dual_lfsr_hex_rng_tb;
   logic        clk_i = 1'b0;
   logic        rst_n = 1'b0;
   logic        en_i  = 1'b0;
   logic [13:0] seg_o;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   logic [7:0]  m_sel;
   logic [15:0] m_data;
   bit          seen_lo [16];
   bit          seen_hi [16];

   always #2.5 clk_i = ~clk_i;

   dual_lfsr_hex_rng u_dut (
      .clk_i (clk_i),
      .rst_n (rst_n),
      .en_i  (en_i),
      .seg_o (seg_o)
   );

   // R7 code table, written from the requirement
   function automatic logic [6:0] code7(input logic [3:0] d);
      logic [6:0] t [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                              7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
      return t[d];
   endfunction

   function automatic logic [7:0] m_value();
      logic [7:0] v;
      for (int i = 0; i < 8; i++) v[i] = m_data[2*i + int'(m_sel[i])];
      return v;
   endfunction

   function automatic logic [13:0] m_seg();
      logic [7:0] v;
      v = m_value();
      return {code7(v[7:4]), code7(v[3:0])};
   endfunction

   task automatic m_reset();
      m_sel  = 8'h01;
      m_data = 16'hACE1;
   endtask

   task automatic m_step();
      m_sel  = {m_sel[6:0],  m_sel[7] ^ m_sel[5] ^ m_sel[4] ^ m_sel[3]};
      m_data = {m_data[14:0], m_data[15] ^ m_data[13] ^ m_data[12] ^ m_data[10]};
   endtask

   task automatic check(input bit ok, input string tag, input logic [13:0] act, input logic [13:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // called at a negedge: drive enable, pass one rising edge, return at negedge
   task automatic cycle(input logic e);
      en_i = e;
      @(posedge clk_i);
      if (e) m_step();
      @(negedge clk_i);
   endtask

   task automatic note_digits();
      for (int d = 0; d < 16; d++) begin
         if (seg_o[6:0]  == code7(4'(d))) seen_lo[d] = 1'b1;
         if (seg_o[13:7] == code7(4'(d))) seen_hi[d] = 1'b1;
      end
   endtask

   task automatic t_reset_state();
      @(negedge clk_i);
      check(seg_o == {7'h5B, 7'h7F}, "R1 seed display", seg_o, {7'h5B, 7'h7F});
      rst_n = 1'b1;
      cycle(1'b0);
      check(seg_o == {7'h5B, 7'h7F}, "R1 seed held after release", seg_o, {7'h5B, 7'h7F});
   endtask

   task automatic t_free_run();
      int bad = 0;
      logic [13:0] a_bad = '0, e_bad = '0;
      for (int k = 0; k < 700; k++) begin
         cycle(1'b1);
         note_digits();
         if (seg_o !== m_seg()) begin
            if (bad == 0) begin a_bad = seg_o; e_bad = m_seg(); end
            bad++;
         end
      end
      check(bad == 0, "R2 R3 R5 R6 R7 free-run match", a_bad, e_bad);
      for (int d = 0; d < 16; d++) begin
         check(seen_lo[d] && seen_hi[d], "R8 R7 digit coverage", 14'(d), 14'(d));
      end
   endtask

   task automatic t_enable_gate();
      logic [13:0] held;
      logic [15:0] pat = 16'b1001_1100_0100_1011;
      held = seg_o;
      for (int k = 0; k < 20; k++) begin
         cycle(1'b0);
         check(seg_o === held, "R4 hold while disabled", seg_o, held);
      end
      for (int r = 0; r < 4; r++) begin
         for (int k = 0; k < 16; k++) begin
            cycle(pat[k]);
            check(seg_o === m_seg(), "R4 R2 R3 gated stepping", seg_o, m_seg());
         end
      end
   endtask

   task automatic t_mid_reset();
      for (int k = 0; k < 37; k++) cycle(1'b1);
      en_i = 1'b1;
      #1 rst_n = 1'b0;
      m_reset();
      @(negedge clk_i);
      check(seg_o === {7'h5B, 7'h7F}, "R9 restart from seeds", seg_o, {7'h5B, 7'h7F});
      rst_n = 1'b1;
      for (int k = 0; k < 40; k++) begin
         cycle(1'b1);
         check(seg_o === m_seg(), "R9 sequence after restart", seg_o, m_seg());
      end
   endtask

   initial begin
      m_reset();
      repeat (3) @(posedge clk_i);
      t_reset_state();
      t_free_run();
      t_enable_gate();
      t_mid_reset();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule